// File: doc/BRIEF.md
# Gated Framebuffer Burst Writer

This block sits between a tile-flush pixel stream and a memory-mapped AXI write port. Rendered pixel words, two 16-bit pixels per 32-bit word, are pushed into a small input FIFO. Each group of eight words leaves as one AXI write burst: an address phase on AW, eight data beats on W, and one response on B. Software decides whether anything reaches memory. The block is disarmed after reset. A canary mode lets only the first 32 bytes of each frame through, which gives a low-risk first write.

A compact register interface holds the control bits and the framebuffer base address. It also exposes a status word and three counters: bytes written, bursts issued and error responses. Host software uses these counters to confirm that a frame reached memory without reading the memory back. A frame begins with the word that carries the start-of-frame marker. Words that arrive before the first marker, and words beyond the selected frame limit, are dropped.

Top module: `fb_burst_writer`

## Requirements
- R1: After reset the registers read back as follows: control (index 0) reads 0x2, base (index 1) reads 0x80000000, status (index 2) reads 0x1, and the byte (index 3), burst (index 4) and error (index 5) counters read 0.
- R2: While control bit 0 (arm) is 0, incoming pixel words start no AW transaction and leave every counter unchanged.
- R3: When armed with control bit 1 (canary) set to 1, each frame produces exactly one burst. That burst carries the first eight words of the frame to the base address.
- R4: When armed with canary set to 0, a 64x64 frame of 16-bit pixels produces 256 bursts, which is 8192 bytes. Words beyond the frame are dropped.
- R5: Every burst uses awlen=7, awsize=2 and awburst=01 (INCR), with all strobes set and wlast on the eighth beat. The k-th burst of a frame (k from 0) goes to base+32*k. Its beats carry the frame's words in arrival order.
- R6: The byte counter rises by 32 and the burst counter by 1 for each completed burst.
- R7: Each B response whose bresp is not 00 increments the error counter. It also sets status bit 1, which stays set until reset.
- R8: A word that is inside the armed frame window but arrives while the FIFO is full sets status bit 2, which stays set until reset.
- R9: Status bit 0 reads 1 only when no burst is in progress, fewer than eight words are buffered and every issued burst has received its B response.
- R10: Once asserted, awvalid and wvalid stay high, and their payloads stay stable, until the matching ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Pixel word present this cycle |
| pix_sof | input | 1 | Marks the first word of a frame |
| pix_data | input | DATA_W | Two packed 16-bit pixels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awaddr | output | ADDR_W | Burst byte address |
| m_awlen | output | 8 | Beats minus one |
| m_awsize | output | 3 | Log2 of bytes per beat |
| m_awburst | output | 2 | Burst type |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Byte strobes |
| m_wlast | output | 1 | Final beat of burst |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_bresp | input | 2 | Write response code |

## Verification
The hardest state to reach from the ports is an overflow inside the armed window. It needs a FIFO that is completely full while the burst engine is blocked, and after that it needs the sticky flag to survive a full drain. The bench builds this case in three steps. First it holds awready and wready low while it streams words back to back. Then it reads the status word. Finally it releases the memory side, lets the buffered bursts finish and reads status again. Half of the table-driven frames toggle wready on alternate cycles, so beats stall in the middle of a burst. The error responses, SLVERR and DECERR, are injected on whole frames so that the error counter has to match the burst counter exactly.

// File: rtl/fbw_pkg.sv
package fbw_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_ADDR = 2'd1,
    ENG_DATA = 2'd2
  } eng_state_e;

  localparam logic [2:0] RI_CTRL   = 3'd0;
  localparam logic [2:0] RI_BASE   = 3'd1;
  localparam logic [2:0] RI_STATUS = 3'd2;
  localparam logic [2:0] RI_BYTES  = 3'd3;
  localparam logic [2:0] RI_BURSTS = 3'd4;
  localparam logic [2:0] RI_ERRS   = 3'd5;

  localparam logic [1:0] RESP_OKAY  = 2'b00;
  localparam logic [1:0] BURST_INCR = 2'b01;

  localparam logic [1:0]  CTRL_RESET = 2'b10;
  localparam logic [31:0] BASE_RESET = 32'h8000_0000;
endpackage

// File: rtl/fbw_in_fifo.sv
module fbw_in_fifo #(
  parameter int DATA_W       = 32,
  parameter int DEPTH        = 16,
  parameter int FULL_WORDS   = 2048,
  parameter int CANARY_WORDS = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = AW + 1,
  localparam int IDX_W = $clog2(FULL_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              canary,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic [DATA_W-1:0] in_data,
  input  logic              pop,
  output logic              head_sof,
  output logic [DATA_W-1:0] head_data,
  output logic [CNT_W-1:0]  count,
  output logic              ovf_pulse
);
  logic [DATA_W:0]    mem [DEPTH];
  logic [AW-1:0]      wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [IDX_W-1:0]   idx_q, idx_d, cur_idx, limit;
  logic               full, want, push;

  always_comb begin
    full      = (cnt_q == CNT_W'(DEPTH));
    cur_idx   = in_sof ? '0 : idx_q;
    limit     = canary ? IDX_W'(CANARY_WORDS) : IDX_W'(FULL_WORDS);
    want      = in_valid && arm && (cur_idx < limit);
    push      = want && !full;
    ovf_pulse = want && full;
    idx_d     = idx_q;
    if (in_valid && (cur_idx < IDX_W'(FULL_WORDS))) idx_d = cur_idx + 1'b1;
    else if (in_valid)                              idx_d = cur_idx;
    wr_ptr_d  = push ? wr_ptr_q + 1'b1 : wr_ptr_q;
    rd_ptr_d  = pop  ? rd_ptr_q + 1'b1 : rd_ptr_q;
    cnt_d     = cnt_q + CNT_W'(push) - CNT_W'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      idx_q    <= IDX_W'(FULL_WORDS);
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      idx_q    <= idx_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q] <= {in_sof, in_data};
  end

  assign {head_sof, head_data} = mem[rd_ptr_q];
  assign count = cnt_q;

  a_r8_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));
  a_r2_no_fill_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> (cnt_q <= $past(cnt_q)));
  a_r8_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/fbw_burst_eng.sv
module fbw_burst_eng
  import fbw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int BEATS  = 8,
  parameter int CNT_W  = 5,
  parameter int OUT_W  = 4,
  localparam int BURST_BYTES = BEATS * DATA_W / 8,
  localparam int BEAT_W      = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  fifo_count,
  input  logic              head_sof,
  input  logic [DATA_W-1:0] head_data,
  output logic              pop,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [ADDR_W-1:0] m_awaddr,
  output logic              m_wvalid,
  input  logic              m_wready,
  output logic [DATA_W-1:0] m_wdata,
  output logic              m_wlast,
  input  logic              m_bvalid,
  input  logic [1:0]        m_bresp,
  output logic              burst_done,
  output logic              resp_err,
  output logic              idle
);
  eng_state_e         state_q, state_d;
  logic [BEAT_W-1:0]  beat_q, beat_d;
  logic [ADDR_W-1:0]  off_q, off_d, addr_q, addr_d;
  logic [OUT_W-1:0]   outst_q, outst_d;
  logic               aw_hs, ready_words;

  always_comb begin
    state_d     = state_q;
    beat_d      = beat_q;
    off_d       = off_q;
    addr_d      = addr_q;
    pop         = 1'b0;
    burst_done  = 1'b0;
    ready_words = (fifo_count >= CNT_W'(BEATS));
    aw_hs       = m_awvalid && m_awready;
    unique case (state_q)
      ENG_IDLE: if (ready_words) begin
        addr_d  = head_sof ? base : base + off_q;
        off_d   = (head_sof ? '0 : off_q) + ADDR_W'(BURST_BYTES);
        state_d = ENG_ADDR;
      end
      ENG_ADDR: if (m_awready) begin
        beat_d  = '0;
        state_d = ENG_DATA;
      end
      ENG_DATA: if (m_wready) begin
        pop    = 1'b1;
        beat_d = beat_q + 1'b1;
        if (m_wlast) begin
          burst_done = 1'b1;
          state_d    = ENG_IDLE;
        end
      end
      default: state_d = ENG_IDLE;
    endcase
    outst_d  = outst_q + OUT_W'(aw_hs) - OUT_W'(m_bvalid);
    resp_err = m_bvalid && (m_bresp != RESP_OKAY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      beat_q  <= '0;
      off_q   <= '0;
      addr_q  <= '0;
      outst_q <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      off_q   <= off_d;
      addr_q  <= addr_d;
      outst_q <= outst_d;
    end
  end

  assign m_awvalid = (state_q == ENG_ADDR);
  assign m_awaddr  = addr_q;
  assign m_wvalid  = (state_q == ENG_DATA);
  assign m_wdata   = head_data;
  assign m_wlast   = (beat_q == BEAT_W'(BEATS - 1));
  assign idle      = (state_q == ENG_IDLE) && !ready_words && (outst_q == '0);

  a_r10_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr));
  a_r10_w_hold: assert property (@(posedge clk) disable iff (!rst_n)
    m_wvalid && !m_wready |=> m_wvalid && $stable(m_wdata) && $stable(m_wlast));
  a_r5_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_awvalid && m_wvalid));
  a_r5_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    m_wvalid && m_wready && m_wlast |=> !m_wvalid);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !m_awvalid && !m_wvalid);
  a_r7_resp_issued: assert property (@(posedge clk) disable iff (!rst_n)
    m_bvalid |-> (outst_q != '0));
endmodule

// File: rtl/fbw_regs.sv
module fbw_regs
  import fbw_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BURST_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              burst_done,
  input  logic              resp_err,
  input  logic              ovf_pulse,
  input  logic              idle,
  output logic              arm,
  output logic              canary,
  output logic [ADDR_W-1:0] base
);
  logic [1:0]        ctrl_q, ctrl_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic              ovf_q, ovf_d, berr_q, berr_d;
  logic [31:0]       bytes_q, bytes_d, bursts_q, bursts_d, errs_q, errs_d;

  always_comb begin
    ctrl_d   = ctrl_q;
    base_d   = base_q;
    if (reg_we && reg_addr == RI_CTRL) ctrl_d = reg_wdata[1:0];
    if (reg_we && reg_addr == RI_BASE) base_d = reg_wdata[ADDR_W-1:0];
    ovf_d    = ovf_q  || ovf_pulse;
    berr_d   = berr_q || resp_err;
    bytes_d  = burst_done ? bytes_q + 32'(BURST_BYTES) : bytes_q;
    bursts_d = burst_done ? bursts_q + 32'd1 : bursts_q;
    errs_d   = resp_err ? errs_q + 32'd1 : errs_q;
    unique case (reg_addr)
      RI_CTRL:   reg_rdata = {30'd0, ctrl_q};
      RI_BASE:   reg_rdata = 32'(base_q);
      RI_STATUS: reg_rdata = {29'd0, ovf_q, berr_q, idle};
      RI_BYTES:  reg_rdata = bytes_q;
      RI_BURSTS: reg_rdata = bursts_q;
      RI_ERRS:   reg_rdata = errs_q;
      default:   reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= CTRL_RESET;
      base_q   <= ADDR_W'(BASE_RESET);
      ovf_q    <= 1'b0;
      berr_q   <= 1'b0;
      bytes_q  <= '0;
      bursts_q <= '0;
      errs_q   <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      base_q   <= base_d;
      ovf_q    <= ovf_d;
      berr_q   <= berr_d;
      bytes_q  <= bytes_d;
      bursts_q <= bursts_d;
      errs_q   <= errs_d;
    end
  end

  assign arm    = ctrl_q[0];
  assign canary = ctrl_q[1];
  assign base   = base_q;

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    berr_q |=> berr_q);
  a_r6_bytes_match: assert property (@(posedge clk) disable iff (!rst_n)
    bytes_q == bursts_q * 32'(BURST_BYTES));
  a_r7_errs_bound: assert property (@(posedge clk) disable iff (!rst_n)
    errs_q <= bursts_q);
endmodule

// File: rtl/fb_burst_writer.sv
module fb_burst_writer
  import fbw_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 32,
  parameter int FRAME_W      = 64,
  parameter int FRAME_H      = 64,
  parameter int PIX_W        = 16,
  parameter int BEATS        = 8,
  parameter int FIFO_DEPTH   = 16,
  parameter int CANARY_BYTES = 32,
  parameter int OUT_W        = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pix_valid,
  input  logic                  pix_sof,
  input  logic [DATA_W-1:0]     pix_data,
  input  logic                  reg_we,
  input  logic [2:0]            reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  output logic                  m_awvalid,
  input  logic                  m_awready,
  output logic [ADDR_W-1:0]     m_awaddr,
  output logic [7:0]            m_awlen,
  output logic [2:0]            m_awsize,
  output logic [1:0]            m_awburst,
  output logic                  m_wvalid,
  input  logic                  m_wready,
  output logic [DATA_W-1:0]     m_wdata,
  output logic [DATA_W/8-1:0]   m_wstrb,
  output logic                  m_wlast,
  input  logic                  m_bvalid,
  output logic                  m_bready,
  input  logic [1:0]            m_bresp
);
  localparam int BYTES_PER_W  = DATA_W / 8;
  localparam int BURST_BYTES  = BEATS * BYTES_PER_W;
  localparam int FRAME_BYTES  = FRAME_W * FRAME_H * PIX_W / 8;
  localparam int FULL_WORDS   = FRAME_BYTES / BYTES_PER_W;
  localparam int CANARY_WORDS = CANARY_BYTES / BYTES_PER_W;
  localparam int CNT_W        = $clog2(FIFO_DEPTH) + 1;

  logic                 rs1_q, rs2_q, rst_core_n;
  logic                 arm, canary, pop, head_sof, ovf_pulse;
  logic                 burst_done, resp_err, idle;
  logic [DATA_W-1:0]    head_data;
  logic [CNT_W-1:0]     fifo_count;
  logic [ADDR_W-1:0]    base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rs2_q, rs1_q} <= 2'b00;
    else        {rs2_q, rs1_q} <= {rs1_q, 1'b1};
  end
  assign rst_core_n = rs2_q;

  fbw_regs #(.ADDR_W(ADDR_W), .BURST_BYTES(BURST_BYTES)) regs_i (
    .clk, .rst_n(rst_core_n), .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .burst_done, .resp_err, .ovf_pulse, .idle, .arm, .canary, .base
  );

  fbw_in_fifo #(
    .DATA_W(DATA_W), .DEPTH(FIFO_DEPTH),
    .FULL_WORDS(FULL_WORDS), .CANARY_WORDS(CANARY_WORDS)
  ) fifo_i (
    .clk, .rst_n(rst_core_n), .arm, .canary,
    .in_valid(pix_valid), .in_sof(pix_sof), .in_data(pix_data),
    .pop, .head_sof, .head_data, .count(fifo_count), .ovf_pulse
  );

  fbw_burst_eng #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BEATS(BEATS),
    .CNT_W(CNT_W), .OUT_W(OUT_W)
  ) eng_i (
    .clk, .rst_n(rst_core_n), .base, .fifo_count, .head_sof, .head_data,
    .pop, .m_awvalid, .m_awready, .m_awaddr, .m_wvalid, .m_wready,
    .m_wdata, .m_wlast, .m_bvalid, .m_bresp, .burst_done, .resp_err, .idle
  );

  assign m_awlen   = 8'(BEATS - 1);
  assign m_awsize  = 3'($clog2(BYTES_PER_W));
  assign m_awburst = BURST_INCR;
  assign m_wstrb   = '1;
  assign m_bready  = 1'b1;
endmodule

// File: tb/fb_burst_writer_tb_top.sv
module fb_burst_writer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {ctrl[1:0], bresp[1:0], base[31:0], expected bursts[15:0]}
  localparam logic [51:0] VECS [NVEC] = '{
    {2'b10, 2'b00, 32'h8000_0000, 16'd0},
    {2'b00, 2'b00, 32'h8000_0000, 16'd0},
    {2'b11, 2'b00, 32'h8000_0000, 16'd1},
    {2'b01, 2'b00, 32'h8000_0000, 16'd256},
    {2'b01, 2'b10, 32'h9000_1000, 16'd256},
    {2'b11, 2'b11, 32'h8400_0040, 16'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_valid = 1'b0, pix_sof = 1'b0;
  logic [31:0] pix_data = '0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic m_awvalid, m_awready = 1'b0, m_wvalid, m_wready = 1'b0, m_wlast;
  logic [31:0] m_awaddr, m_wdata;
  logic [7:0] m_awlen;
  logic [2:0] m_awsize;
  logic [1:0] m_awburst, m_bresp;
  logic [3:0] m_wstrb;
  logic m_bvalid = 1'b0, m_bready;

  int n_chk = 0, n_fail = 0;
  logic stall = 1'b0, slow = 1'b0;
  logic [1:0] cur_resp = 2'b00;
  logic [31:0] cur_base = 32'h8000_0000;
  int aw_k = 0, w_k = 0, addr_bad = 0, data_bad = 0, pend = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fb_burst_writer dut_i (
    .clk, .rst_n, .pix_valid, .pix_sof, .pix_data, .reg_we, .reg_addr,
    .reg_wdata, .reg_rdata, .m_awvalid, .m_awready, .m_awaddr, .m_awlen,
    .m_awsize, .m_awburst, .m_wvalid, .m_wready, .m_wdata, .m_wstrb,
    .m_wlast, .m_bvalid, .m_bready, .m_bresp
  );

  function automatic logic [31:0] pat(int i);
    return {16'(i) ^ 16'hA5A5, 16'(i)};
  endfunction

  // memory-side model
  always @(negedge clk) begin
    m_awready <= !stall;
    m_wready  <= stall ? 1'b0 : (slow ? !m_wready : 1'b1);
  end
  assign m_bresp = cur_resp;
  always @(posedge clk) begin
    int nxt;
    nxt = pend + ((m_wvalid && m_wready && m_wlast) ? 1 : 0) - (m_bvalid ? 1 : 0);
    pend     <= nxt;
    m_bvalid <= (nxt != 0) && !m_bvalid;
  end
  // R5 monitors
  always @(posedge clk) begin
    if (m_awvalid && m_awready) begin
      if (m_awaddr != cur_base + 32'(aw_k * 32) || m_awlen != 8'd7 ||
          m_awsize != 3'd2 || m_awburst != 2'b01) addr_bad = addr_bad + 1;
      aw_k = aw_k + 1;
    end
    if (m_wvalid && m_wready) begin
      if (m_wdata != pat(w_k) || m_wstrb != 4'hF ||
          m_wlast != ((w_k % 8) == 7)) data_bad = data_bad + 1;
      w_k = w_k + 1;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic send_frame(int n, int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pix_valid = 1'b1; pix_sof = (i == 0); pix_data = pat(i);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk); pix_valid = 1'b0; pix_sof = 1'b0;
      end
    end
    @(negedge clk); pix_valid = 1'b0; pix_sof = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 20000; k++) begin
      rd(3'd2, s);
      if (s[0]) break;
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int exp_bytes, exp_bursts, exp_errs;
    logic err_seen;
    exp_bytes = 0; exp_bursts = 0; exp_errs = 0; err_seen = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(3'd0, v); chk("R1 ctrl", v, 32'h2);
    rd(3'd1, v); chk("R1 base", v, 32'h8000_0000);
    rd(3'd2, v); chk("R1 status", v, 32'h1);
    rd(3'd3, v); chk("R1 bytes", v, 0);
    rd(3'd4, v); chk("R1 bursts", v, 0);
    rd(3'd5, v); chk("R1 errs", v, 0);

    // table walk: R2 R3 R4 R5 R6 R7 R9
    for (int n = 0; n < NVEC; n++) begin
      logic [51:0] e;
      e = VECS[n];
      wr(3'd1, e[47:16]);
      wr(3'd0, {30'd0, e[51:50]});
      cur_resp = e[49:48];
      cur_base = e[47:16];
      slow = n[0];
      aw_k = 0; w_k = 0; addr_bad = 0; data_bad = 0;
      send_frame(2048, 2);
      wait_idle();
      exp_bursts += int'(e[15:0]);
      exp_bytes  += 32 * int'(e[15:0]);
      if (e[49:48] != 2'b00) begin
        exp_errs += int'(e[15:0]);
        if (e[15:0] != 0) err_seen = 1'b1;
      end
      chk("R2/R3/R4 aw count", aw_k, 32'(e[15:0]));
      chk("R5 burst fields and address", addr_bad, 0);
      chk("R5 beat data", data_bad, 0);
      rd(3'd3, v); chk("R6 bytes", v, 32'(exp_bytes));
      rd(3'd4, v); chk("R6 bursts", v, 32'(exp_bursts));
      rd(3'd5, v); chk("R7 errs", v, 32'(exp_errs));
      rd(3'd2, v); chk("R9 R7 status", v, {29'd0, 1'b0, err_seen, 1'b1});
    end

    // R8 overflow with memory side blocked
    slow = 1'b0; cur_resp = 2'b00; cur_base = 32'h8000_0000;
    wr(3'd1, 32'h8000_0000);
    stall = 1'b1;
    wr(3'd0, 32'h1);
    aw_k = 0; w_k = 0;
    send_frame(20, 0);
    repeat (4) @(negedge clk);
    rd(3'd2, v); chk("R8 overflow set, R9 not idle", v, {29'd0, 1'b1, err_seen, 1'b0});
    stall = 1'b0;
    wait_idle();
    rd(3'd2, v); chk("R8 overflow sticky", v, {29'd0, 1'b1, err_seen, 1'b1});
    rd(3'd4, v); chk("R6 bursts after drain", v, 32'(exp_bursts + 2));
    chk("R5 drained data", data_bad, 0);
    finish_run();
  end
endmodule